// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is a watchdog for a small microcontroller. Software reaches it over a plain register bus made of a word address, write data, a write strobe and combinational read data. Two word locations matter. The control location turns the watchdog on or off, but only when the low half-word of the written data matches one of two fixed 16-bit keys. The restart location reloads the countdown on any write, whatever the data.

While the watchdog is enabled, a down-counter loaded with the parameter `RELOAD` decrements once per clock. When it reaches zero, the block raises a reset request for exactly one clock. The counter then stays at zero until software reloads it. A system reset controller is expected to act on that pulse. The counter stops whenever the watchdog is disabled.

Top module: `wdt_guard`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, the watchdog is disabled, `rst_req` is low, and reads of the control word (address 0) and the restart word (address 1) return zero.
- R2: A write to address 0 whose data bits [15:0] equal 0xEABE enables the watchdog, whatever the upper data bits are. A later read of address 0 then returns 1 in bit 0 and zero in all other bits.
- R3: A write to address 0 whose data bits [15:0] equal 0xDEAD disables the watchdog, whatever the upper data bits are. Address 0 then reads 0, and no reset request is raised while the watchdog stays disabled.
- R4: A write to address 0 whose bits [15:0] match neither key leaves the enable state unchanged.
- R5: A write of any data to address 1 reloads the counter with `RELOAD`. Address 1 always reads zero.
- R6: An enable-key write reloads the counter with `RELOAD`, including when the watchdog is already enabled.
- R7: If the last reload happens on clock edge W and the watchdog stays enabled with no further reload, `rst_req` is high for exactly the one cycle that follows edge W+`RELOAD`.
- R8: After an expiry the counter stays at zero, and no further reset request is raised until a reload happens.
- R9: A write to address 1 while the watchdog is disabled does not enable it and does not cause a reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with `RELOAD` set to 12 and a 32-bit data path. With a reload this short, a full expiry, the hold at zero that follows it, and a chain of restarts that each land before expiry all fit in a few dozen cycles. That makes the exact cycle of every expected pulse easy to predict and compare. The wide data path lets the bench put non-zero upper bits beside each key, which shows that only the low half-word is decoded.

// File: rtl/wdt_guard_pkg.sv
// Package: shared constants and types for the key-protected watchdog.
// Assumes a word-addressed bus on which only two locations are decoded.
package wdt_guard_pkg;

    localparam int unsigned KEY_W        = 16;
    localparam logic [KEY_W-1:0] KEY_ON  = 16'hEABE;
    localparam logic [KEY_W-1:0] KEY_OFF = 16'hDEAD;

    localparam int unsigned CTRL_WORD    = 0;
    localparam int unsigned RESTART_WORD = 1;

    // Decoded single-cycle events produced by a bus write
    typedef struct packed {
        logic arm;     // enable key written
        logic disarm;  // disable key written
        logic kick;    // restart location written
    } wdt_evt_t;

endpackage

// File: rtl/wdt_bus_decode.sv
// Module: turns one bus write into arm, disarm and kick events.
// Assumes: at most one write per cycle; keys are compared on the low half-word only.
module wdt_bus_decode
    import wdt_guard_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [KEY_W-1:0]  key_field,
    input  logic              bus_we,
    output wdt_evt_t          evt
);

    logic hit_ctrl;
    logic hit_restart;

    // Address match for the two decoded words
    always_comb begin
        hit_ctrl    = bus_we && (bus_addr == ADDR_W'(CTRL_WORD));
        hit_restart = bus_we && (bus_addr == ADDR_W'(RESTART_WORD));
    end

    // Key comparison; any other value produces no event
    always_comb begin
        evt.arm    = hit_ctrl && (key_field == KEY_ON);
        evt.disarm = hit_ctrl && (key_field == KEY_OFF);
        evt.kick   = hit_restart;
    end

endmodule

// File: rtl/wdt_enable_reg.sv
// Module: holds the watchdog enable state.
// Assumes: arm and disarm are never both high (the keys differ).
module wdt_enable_reg
    import wdt_guard_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wdt_evt_t evt,
    output logic     enabled
);

    // Set on the enable key, clear on the disable key, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled <= 1'b0;
        end else if (evt.arm) begin
            enabled <= 1'b1;
        end else if (evt.disarm) begin
            enabled <= 1'b0;
        end
    end

endmodule

// File: rtl/wdt_countdown.sv
// Module: down-counter that raises a one-cycle expiry pulse on reaching zero.
// Assumes: RELOAD >= 1. Reload has priority over counting. The counter holds
// at zero after expiry and holds its value while disabled.
module wdt_countdown #(
    parameter int unsigned RELOAD = 50000,
    parameter int unsigned CNT_W  = $clog2(RELOAD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enabled,
    input  logic             reload,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(RELOAD);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    // Reload, decrement while enabled, and flag the 1 -> 0 transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= LOAD_VAL;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (reload) begin
                cnt <= LOAD_VAL;
            end else if (enabled && (cnt != '0)) begin
                cnt <= cnt - ONE;
                if (cnt == ONE) begin
                    expire <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wdt_guard.sv
// Module: key-protected watchdog top. Word 0 takes enable and disable keys
// and reads back the enable bit. Word 1 restarts the countdown on any write
// and reads zero. Assumes DATA_W > 16 and a combinational read path.
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned RELOAD = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);

    localparam int unsigned CNT_W = $clog2(RELOAD + 1);

    wdt_evt_t         evt;
    logic             enabled_q;
    logic [CNT_W-1:0] cnt_q;
    logic             unused_upper;

    // Upper write-data bits take no part in key decoding
    assign unused_upper = ^bus_wdata[DATA_W-1:KEY_W];

    wdt_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_addr  (bus_addr),
        .key_field (bus_wdata[KEY_W-1:0]),
        .bus_we    (bus_we),
        .evt       (evt)
    );

    wdt_enable_reg u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .enabled (enabled_q)
    );

    wdt_countdown #(.RELOAD(RELOAD), .CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .enabled (enabled_q),
        .reload  (evt.arm | evt.kick),
        .cnt     (cnt_q),
        .expire  (rst_req)
    );

    // Read mux: enable bit on word 0; zero everywhere else
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_WORD)) begin
            bus_rdata[0] = enabled_q;
        end
    end

endmodule

// File: rtl/wdt_guard_sva.sv
// Checker: temporal properties of the watchdog, bound to wdt_guard.
// Assumes it sees the top's ports plus its enable state and counter.
module wdt_guard_sva
    import wdt_guard_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned RELOAD = 50000,
    parameter int unsigned CNT_W  = $clog2(RELOAD + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              rst_req,
    input logic              enabled,
    input logic [CNT_W-1:0]  cnt
);

    logic wr_ctrl, wr_restart, key_on, key_off;

    // Checker-side view of the bus write
    always_comb begin
        wr_ctrl    = bus_we && (bus_addr == ADDR_W'(CTRL_WORD));
        wr_restart = bus_we && (bus_addr == ADDR_W'(RESTART_WORD));
        key_on     = bus_wdata[KEY_W-1:0] == KEY_ON;
        key_off    = bus_wdata[KEY_W-1:0] == KEY_OFF;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!rst_req && !enabled));

    p_key_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && key_on) |=> enabled);

    p_key_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && key_off) |=> !enabled);

    p_key_other_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !key_on && !key_off) |=> (enabled == $past(enabled)));

    p_restart_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_restart |=> (cnt == CNT_W'(RELOAD)));

    p_arm_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && key_on) |=> (cnt == CNT_W'(RELOAD)));

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_pulse_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt == '0));

    p_hold_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !wr_restart && !(wr_ctrl && key_on)) |=> (cnt == '0 && !rst_req));

    p_restart_no_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_restart && !enabled) |=> !enabled);

endmodule

bind wdt_guard wdt_guard_sva #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RELOAD (RELOAD)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .rst_req   (rst_req),
    .enabled   (enabled_q),
    .cnt       (cnt_q)
);

// File: tb/wdt_guard_tb_top.sv
// Bench: scoreboard of expected expiry cycles plus register read checks.
module wdt_guard_tb_top;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned RELOAD = 12;
    localparam logic [ADDR_W-1:0] A_CTRL = 0;
    localparam logic [ADDR_W-1:0] A_RST  = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              rst_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_edge = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    wdt_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RELOAD(RELOAD)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: one write, strobe high across a single clock edge
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        last_edge = cyc;
    endtask

    task automatic bus_read(input string req, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    // Driver: queue the cycle in which an expiry pulse must appear
    task automatic expect_expiry();
        exp_q.push_back(last_edge + int'(RELOAD));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: every pulse must match the head of the expectation queue
    always @(negedge clk) begin
        if (rst_n && rst_req) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R8 unexpected reset request actual_cycle=%0d expected=none", cyc);
            end else begin
                int want;
                want = exp_q.pop_front();
                check("R7 expiry cycle", DATA_W'(cyc), DATA_W'(want));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 rst_req in reset", DATA_W'(rst_req), '0);
        rst_n = 1'b1;
        bus_read("R1 control reads zero", A_CTRL, '0);
        check("R1 rst_req after reset", DATA_W'(rst_req), '0);
        bus_read("R1 restart reads zero", A_RST, '0);

        // R4: non-key value while disabled
        bus_write(A_CTRL, 32'h0000_1234);
        bus_read("R4 bad key keeps disabled", A_CTRL, '0);

        // R9: restart while disabled neither enables nor fires
        bus_write(A_RST, 32'hFFFF_FFFF);
        bus_read("R9 restart keeps disabled", A_CTRL, '0);
        idle(3 * RELOAD);

        // R2 / R7 / R8: enable with junk upper bits, expire once, then hold
        bus_write(A_CTRL, 32'hFFFF_EABE);
        expect_expiry();
        bus_read("R2 enable bit set", A_CTRL, 32'h1);
        idle(4 * RELOAD);
        check("R7 pulse consumed", DATA_W'(exp_q.size()), '0);

        // R5: periodic restarts keep it quiet, then one expiry
        bus_write(A_RST, 32'h0);
        for (int i = 0; i < 5; i++) begin
            idle(RELOAD / 3);
            bus_write(A_RST, DATA_W'(i * 32'h1111));
        end
        expect_expiry();
        bus_read("R5 restart word reads zero", A_RST, '0);
        idle(2 * RELOAD);
        check("R5 single expiry after restarts", DATA_W'(exp_q.size()), '0);

        // R4: non-key value while enabled
        bus_write(A_CTRL, 32'h0000_DEAE);
        bus_read("R4 bad key keeps enabled", A_CTRL, 32'h1);

        // R6: second enable write restarts the count
        bus_write(A_CTRL, 32'h0000_EABE);
        idle(RELOAD - 4);
        bus_write(A_CTRL, 32'h0000_EABE);
        expect_expiry();
        idle(2 * RELOAD);
        check("R6 re-arm delays expiry", DATA_W'(exp_q.size()), '0);

        // R3: disable mid-count, no pulse afterwards
        bus_write(A_CTRL, 32'h0000_EABE);
        idle(4);
        bus_write(A_CTRL, 32'h5A5A_DEAD);
        bus_read("R3 disable clears bit", A_CTRL, '0);
        idle(3 * RELOAD);
        check("R3 no pending expiry", DATA_W'(exp_q.size()), '0);

        finish_run();
    end

endmodule